// File: doc/BRIEF.md
# GPIO Edge Interrupt Mask Controller

This block watches a small group of general-purpose input lines and raises one interrupt line when an enabled edge occurs on any of them. Two 8-bit mask registers choose which edges count. The falling mask enables interrupts on a 1-to-0 change of a line. The rising mask enables interrupts on a 0-to-1 change. Each mask has a set address and a clear address. A write changes only the bits whose data bit is 1, so software never needs a read-modify-write to change one bit.

The inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one clock earlier. An edge on a line whose mask bit is enabled sets a sticky status bit for that line. The interrupt output is the OR of the status bits. The host reads the status at its own address and clears bits by writing 1s to them. The register bus has address, write data, a write strobe and read data. Reads are combinational from the address.

Top module: `gpio_irq_mask`

## Requirements
- R1: After reset, both masks read 0x00, the status reads 0x00 and irq_o is 0.
- R2: A write to 0x1C (falling mask) or 0x1E (rising mask) sets every mask bit whose data bit is 1 and leaves the other bits unchanged. For example, 0x28 with 0x88 written gives 0xA8.
- R3: A write to 0x1D (falling mask) or 0x1F (rising mask) clears every mask bit whose data bit is 1 and leaves the other bits unchanged. For example, 0xA8 with 0x88 written gives 0x20.
- R4: Reading the set address or the clear address of a pair returns the same current 8-bit mask. All 8 bits, including bits 3 to 7, are storage that can be set and cleared. The two masks are independent of each other.
- R5: Mask bit i (i = 0 to 2) belongs to line gpio_i[i]. When falling-mask bit i is 1, a 1-to-0 change on that line sets status bit i. The status is read at 0x20: bits 2 to 0 hold the status and bits 7 to 3 read 0.
- R6: When rising-mask bit i is 1, a 0-to-1 change on line i sets status bit i.
- R7: An edge on a line whose mask bit for that direction is 0 leaves the status unchanged.
- R8: Status bits stay set until cleared. irq_o is 1 exactly when any status bit is 1. Writing to 0x20 clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R9: Writes to any address other than 0x1C to 0x20 change no register. Reads from those addresses return 0x00.
- R10: The status bit becomes visible after the third rising clock edge that follows a change of gpio_i. It is not set after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data for addr_i |
| gpio_i | input | 3 | Asynchronous input lines |
| irq_o | output | 1 | Interrupt, OR of the status bits |

## Verification
The hardest case to reach is a status bit set by an edge whose mask was changed by a partial write a short time before. The bench must also show that edges on lines not enabled stay invisible while other lines are enabled. To get there, the stimulus mixes random set and clear writes on all five addresses with random toggles of the input lines. After each toggle it waits until the synchronizer and the edge compare have settled. It then compares the status and irq_o against a model that tracks both masks bit by bit. Directed steps cover the documented set and clear example, the exact three-edge latency and writes to unmapped addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] FALL_SET_ADDR = 8'h1C;
  localparam logic [ADDR_W-1:0] FALL_CLR_ADDR = 8'h1D;
  localparam logic [ADDR_W-1:0] RISE_SET_ADDR = 8'h1E;
  localparam logic [ADDR_W-1:0] RISE_CLR_ADDR = 8'h1F;
  localparam logic [ADDR_W-1:0] STAT_ADDR     = 8'h20;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
  import gpio_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SET_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] mask_q;
  logic              set_hit, clr_hit;

  assign set_hit = we_i && (addr_i == SET_ADDR);
  assign clr_hit = we_i && (addr_i == CLR_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      mask_q <= '0;
    else if (set_hit) mask_q <= mask_q | wdata_i;
    else if (clr_hit) mask_q <= mask_q & ~wdata_i;

  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] keep;

  // a new hit wins over a same-cycle clear
  assign keep = clr_i ? (stat_q & ~clr_bits_i) : stat_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= keep | hit_i;

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_mask.sv
module gpio_irq_mask
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_GPIO      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_GPIO-1:0] gpio_i,
  output logic              irq_o
);
  logic [N_GPIO-1:0] gpio_s, rise, fall, hits, status;
  logic [DATA_W-1:0] fall_mask, rise_mask;
  logic              stat_we;

  gpio_sync #(.N(N_GPIO), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(gpio_i), .q_o(gpio_s)
  );

  gpio_edge_det #(.N(N_GPIO)) u_edge (
    .clk_i, .rst_ni, .lvl_i(gpio_s), .rise_o(rise), .fall_o(fall)
  );

  gpio_mask_reg #(.SET_ADDR(FALL_SET_ADDR), .CLR_ADDR(FALL_CLR_ADDR)) u_fall (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .mask_o(fall_mask)
  );

  gpio_mask_reg #(.SET_ADDR(RISE_SET_ADDR), .CLR_ADDR(RISE_CLR_ADDR)) u_rise (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .mask_o(rise_mask)
  );

  assign hits    = (rise & rise_mask[N_GPIO-1:0]) | (fall & fall_mask[N_GPIO-1:0]);
  assign stat_we = we_i && (addr_i == STAT_ADDR);

  gpio_status #(.N(N_GPIO)) u_stat (
    .clk_i, .rst_ni, .hit_i(hits), .clr_i(stat_we),
    .clr_bits_i(wdata_i[N_GPIO-1:0]), .stat_o(status)
  );

  assign irq_o = |status;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      FALL_SET_ADDR, FALL_CLR_ADDR: rdata_o = fall_mask;
      RISE_SET_ADDR, RISE_CLR_ADDR: rdata_o = rise_mask;
      STAT_ADDR:                    rdata_o[N_GPIO-1:0] = status;
      default:                      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_mask_chk.sv
module gpio_irq_mask_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_GPIO = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] fall_mask,
  input logic [DATA_W-1:0] rise_mask,
  input logic [N_GPIO-1:0] status
);
  logic unmapped;
  assign unmapped = (addr_i < FALL_SET_ADDR) || (addr_i > STAT_ADDR);

  p_fall_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == FALL_SET_ADDR) |=>
      fall_mask == ($past(fall_mask) | $past(wdata_i)));

  p_rise_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RISE_SET_ADDR) |=>
      rise_mask == ($past(rise_mask) | $past(wdata_i)));

  p_fall_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == FALL_CLR_ADDR) |=>
      fall_mask == ($past(fall_mask) & ~$past(wdata_i)));

  p_rise_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RISE_CLR_ADDR) |=>
      rise_mask == ($past(rise_mask) & ~$past(wdata_i)));

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || unmapped) |=> ($stable(fall_mask) && $stable(rise_mask)));

  p_unmapped_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> rdata_o == '0);

  p_masked_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & ~$past(status) &
               ~($past(fall_mask[N_GPIO-1:0]) | $past(rise_mask[N_GPIO-1:0]))) == '0));
endmodule

bind gpio_irq_mask gpio_irq_mask_chk #(.N_GPIO(N_GPIO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .rdata_o(rdata_o), .fall_mask(fall_mask),
  .rise_mask(rise_mask), .status(status)
);

// File: tb/gpio_irq_mask_tb.sv
module gpio_irq_mask_tb;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic [7:0] addr_i = 0, wdata_i = 0;
  logic       we_i = 0;
  logic [7:0] rdata_o;
  logic [2:0] gpio_i = 0;
  logic       irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_fall = 0, m_rise = 0;
  logic [2:0] m_stat = 0, m_gpio = 0;

  always #2 clk_i = ~clk_i;

  gpio_irq_mask u_dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk_i);
    we_i = 0;
    case (a)
      8'h1C: m_fall = m_fall | d;
      8'h1D: m_fall = m_fall & ~d;
      8'h1E: m_rise = m_rise | d;
      8'h1F: m_rise = m_rise & ~d;
      8'h20: m_stat = m_stat & ~d[2:0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic drive_gpio(input logic [2:0] g);
    @(negedge clk_i);
    gpio_i = g;
    wait_clks(4);
    m_stat = m_stat | ((g & ~m_gpio) & m_rise[2:0]) | ((~g & m_gpio) & m_fall[2:0]);
    m_gpio = g;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    bus_read(8'h1C, v); check({tag, " fall@1C"}, v, m_fall);
    bus_read(8'h1D, v); check({tag, " fall@1D"}, v, m_fall);
    bus_read(8'h1E, v); check({tag, " rise@1E"}, v, m_rise);
    bus_read(8'h1F, v); check({tag, " rise@1F"}, v, m_rise);
    bus_read(8'h20, v); check({tag, " status"}, v, {5'b0, m_stat});
    check({tag, " irq"}, {7'b0, irq_o}, {7'b0, |m_stat});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    wait_clks(3);
    rst_ni = 1;
    wait_clks(1);
    check_all("R1 reset");

    // R2 / R3 documented example on the falling mask
    bus_write(8'h1C, 8'h28);
    bus_write(8'h1C, 8'h88);
    bus_read(8'h1D, v); check("R2 set 0x88 -> A8", v, 8'hA8);
    bus_write(8'h1D, 8'h88);
    bus_read(8'h1C, v); check("R3 clr 0x88 -> 20", v, 8'h20);
    bus_read(8'h1E, v); check("R4 rise untouched", v, 8'h00);
    bus_write(8'h1E, 8'hF0);
    bus_write(8'h1F, 8'h30);
    bus_read(8'h1F, v); check("R4 upper bits storage", v, 8'hC0);
    bus_read(8'h1D, v); check("R4 fall independent", v, 8'h20);

    // R9 unmapped
    bus_write(8'h1B, 8'hFF); bus_write(8'h21, 8'hFF); bus_write(8'hFF, 8'hFF);
    bus_write(8'h00, 8'hFF);
    check_all("R9 after unmapped writes");
    bus_read(8'h1B, v); check("R9 read 1B", v, 8'h00);
    bus_read(8'h21, v); check("R9 read 21", v, 8'h00);
    bus_read(8'hFF, v); check("R9 read FF", v, 8'h00);

    // R7 edges with no enabled bits (low mask bits clear)
    drive_gpio(3'b111);
    drive_gpio(3'b000);
    check_all("R7 no enable");

    // R10 latency and R6 rising edge on line 1
    bus_write(8'h1E, 8'h02);
    @(negedge clk_i); gpio_i = 3'b010;
    wait_clks(2);
    check("R10 not set after 2 edges", {7'b0, irq_o}, 8'h00);
    wait_clks(1);
    check("R10 set after 3 edges", {7'b0, irq_o}, 8'h01);
    bus_read(8'h20, v); check("R6 rise line1", v, 8'h02);
    m_stat = 3'b010; m_gpio = 3'b010;

    // R5 falling on line 2, R7 falling on line 1 not enabled
    bus_write(8'h1C, 8'h04);
    drive_gpio(3'b100);
    drive_gpio(3'b000);
    bus_read(8'h20, v); check("R5 fall line2", v, 8'h06);

    // R8 partial clear keeps the rest
    bus_write(8'h20, 8'h02);
    bus_read(8'h20, v); check("R8 partial clear", v, 8'h04);
    check("R8 irq still high", {7'b0, irq_o}, 8'h01);
    bus_write(8'h20, 8'hFF);
    check("R8 irq low after clear", {7'b0, irq_o}, 8'h00);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 6) begin
        logic [7:0] a;
        a = (op < 5) ? 8'(8'h1C + op) : 8'($urandom_range(0, 255));
        bus_write(a, 8'($urandom_range(0, 255)));
      end else begin
        drive_gpio(3'($urandom_range(0, 7)));
      end
      if (it % 8 == 7) check_all("R2 R3 R5 R6 R7 R8 R9 random");
    end
    check_all("R4 final");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule